// File: doc/BRIEF.md
# Bit-Mapped Graphics Overlay Memory

This block stores a monochrome bitmap of 384 by 192 dots that is laid over a character-mode text picture. A host writes and reads the bitmap through a simple register-style port, one 6-dot cell at a time. Each cell covers the width of one character. The host address is not a linear index. It is a packed field of character column, character row and scan line within the character cell. The bitmap is held apart from the text picture, so a host read always returns exactly what was stored.

On the display side, the external video timing presents the row, scan line and column of the next character and pulses a load strobe once per 6 dot clocks, in step with the text dot shifter. The block fetches the matching cell, shifts it out with bit 0 first, and ORs each overlay dot onto the incoming text dot. A global overlay enable is latched once per frame, when vertical blanking begins. While the latched enable is low, the output carries the text dots alone.

Top module: `gfx_overlay`

## Requirements
- R1: While rst_ni is low, host_rdata_o and pix_o are 0 and the latched overlay enable is cleared, so no overlay dot appears until a later vertical blanking latches a 1.
- R2: The host address selects the column with bits [5:0], the character row with bits [9:6] and the scan line with bits [13:10]. Bits [15:14] are ignored.
- R3: A host write with host_we_i high stores host_wdata_i at the clock edge. host_rdata_o shows the cell addressed in the previous cycle. A read and a write of the same cell in one cycle return the old content.
- R4: When the scan-line field is 12 to 15, a write changes no cell and the read data is 0.
- R5: Host reads return the stored overlay bits. Text dots, the enable and display activity have no effect on them.
- R6: When disp_load_i is high at an edge, the cell at the display row/scan/column is captured. The k-th following edge (k = 1 to 6) drives pix_o from cell bit k-1 together with the text dot presented just before that edge.
- R7: While the latched enable is 1, pix_o is the OR of that text dot and that overlay dot.
- R8: The overlay enable is sampled from ovl_en_i only at an edge where vblank_i is high and was low at the previous edge. At all other times changes on ovl_en_i have no effect.
- R9: While the latched enable is 0, pix_o equals text_dot_i delayed by one cycle.
- R10: Once the 6 dots of a captured cell have been shifted out, and no new load has occurred, the overlay contributes 0.
- R11: A display fetch with a scan-line value of 12 to 15 captures an all-zero cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | 16 | Packed host address: scan line, row, column |
| host_we_i | input | 1 | Host write strobe |
| host_wdata_i | input | 6 | Cell data to write, bit 0 is the leftmost dot |
| host_rdata_o | output | 6 | Registered raw cell read data |
| disp_row_i | input | 4 | Character row of the next display cell |
| disp_scan_i | input | 4 | Scan line within the character of the next display cell |
| disp_col_i | input | 6 | Column of the next display cell |
| disp_load_i | input | 1 | Cell load strobe, in step with the text shifter |
| text_dot_i | input | 1 | Current text video dot |
| vblank_i | input | 1 | Vertical blanking indicator |
| ovl_en_i | input | 1 | Overlay enable request |
| pix_o | output | 1 | Merged video dot, active high |

## Verification
A wrong field split or line index in the address decoder stores a cell where the host does not expect it. That shows up two cycles after a write, when the same or an aliased address is read back, or six dots later on the display. A shifter that shifts the wrong way or loads late corrupts pix_o within the six dots after the next load strobe. A wrong enable latch shows on the very next displayed overlay dot after a vertical blanking edge, or after a change on ovl_en_i outside blanking. The reference model follows each cell, the shift position and the latched enable on every clock, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/gfx_ovl_pkg.sv
package gfx_ovl_pkg;
  localparam int CELL_W = 6;
  localparam int HADDR_W = 16;
  typedef logic [CELL_W-1:0] cell_t;
endpackage

// File: rtl/gfx_ovl_addr_dec.sv
module gfx_ovl_addr_dec
  import gfx_ovl_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int ROWS  = 16,
  parameter int SCANS = 12,
  localparam int COL_AW  = $clog2(COLS),
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int SCAN_AW = $clog2(SCANS),
  localparam int LINE_W  = $clog2(ROWS * SCANS),
  localparam int FIELD_W = COL_AW + ROW_AW + SCAN_AW
) (
  input  logic [HADDR_W-1:0] addr_i,
  output logic [LINE_W-1:0]  line_o,
  output logic [COL_AW-1:0]  col_o,
  output logic               valid_o
);
  logic [ROW_AW-1:0]  row;
  logic [SCAN_AW-1:0] scan;
  logic               unused_hi;

  assign col_o     = addr_i[COL_AW-1:0];
  assign row       = addr_i[COL_AW +: ROW_AW];
  assign scan      = addr_i[COL_AW+ROW_AW +: SCAN_AW];
  assign unused_hi = ^addr_i[HADDR_W-1:FIELD_W];

  // display line index: rows stacked, scan lines inside each row
  assign line_o  = LINE_W'(row) * LINE_W'(SCANS) + LINE_W'(scan);
  assign valid_o = (int'(scan) < SCANS) && (int'(row) < ROWS) && (int'(col_o) < COLS);
endmodule

// File: rtl/gfx_ovl_store.sv
module gfx_ovl_store
  import gfx_ovl_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int LINES = 192,
  localparam int COL_AW = $clog2(COLS),
  localparam int LINE_W = $clog2(LINES),
  localparam int WORD_W = COLS * CELL_W,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [COL_AW-1:0] wr_col_i,
  input  cell_t             wr_data_i,
  input  logic              rd_valid_i,
  input  logic [LINE_W-1:0] rd_line_i,
  input  logic [COL_AW-1:0] rd_col_i,
  output cell_t             rd_data_o,
  input  logic              fetch_valid_i,
  input  logic [LINE_W-1:0] fetch_line_i,
  input  logic [COL_AW-1:0] fetch_col_i,
  output cell_t             fetch_data_o
);
  // one wide word per scan line keeps the array depth at LINES
  logic [WORD_W-1:0] mem_q [LINES];
  cell_t             rd_data_q;
  logic [BIT_W-1:0]  wr_bit, rd_bit, fetch_bit;

  assign wr_bit    = BIT_W'(wr_col_i) * BIT_W'(CELL_W);
  assign rd_bit    = BIT_W'(rd_col_i) * BIT_W'(CELL_W);
  assign fetch_bit = BIT_W'(fetch_col_i) * BIT_W'(CELL_W);

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_line_i][wr_bit +: CELL_W] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rd_data_q <= '0;
    else if (rd_valid_i) rd_data_q <= mem_q[rd_line_i][rd_bit +: CELL_W];
    else                 rd_data_q <= '0;
  end

  assign rd_data_o    = rd_data_q;
  assign fetch_data_o = fetch_valid_i ? mem_q[fetch_line_i][fetch_bit +: CELL_W] : '0;

  // R3
  write_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && $past(wr_en_i) && rd_line_i == $past(wr_line_i) && rd_col_i == $past(wr_col_i))
      |=> rd_data_o == $past(wr_data_i, 2));
endmodule

// File: rtl/gfx_ovl_merge.sv
module gfx_ovl_merge
  import gfx_ovl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  cell_t cell_i,
  input  logic  text_dot_i,
  input  logic  vblank_i,
  input  logic  ovl_en_i,
  output logic  pix_o
);
  cell_t sh_q;
  logic  en_q, vb_q, pix_q;
  logic  vb_rise;

  assign vb_rise = vblank_i & ~vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      en_q  <= 1'b0;
      vb_q  <= 1'b0;
      pix_q <= 1'b0;
    end else begin
      // bit 0 leaves first; zeros fill behind
      sh_q  <= load_i ? cell_i : {1'b0, sh_q[CELL_W-1:1]};
      pix_q <= text_dot_i | (en_q & sh_q[0]);
      vb_q  <= vblank_i;
      if (vb_rise) en_q <= ovl_en_i;
    end
  end

  assign pix_o = pix_q;

  // R7
  text_passes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    text_dot_i |=> pix_o);

  // R9
  disabled_text_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> pix_o == $past(text_dot_i));

  // R8
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vblank_i && !vb_q) |=> $stable(en_q));
endmodule

// File: rtl/gfx_overlay.sv
module gfx_overlay
  import gfx_ovl_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int ROWS  = 16,
  parameter int SCANS = 12,
  localparam int COL_AW   = $clog2(COLS),
  localparam int ROW_AW   = $clog2(ROWS),
  localparam int SCAN_AW  = $clog2(SCANS),
  localparam int LINES    = ROWS * SCANS,
  localparam int LINE_W   = $clog2(LINES),
  localparam int SCAN_LSB = COL_AW + ROW_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic               host_we_i,
  input  logic [CELL_W-1:0]  host_wdata_i,
  output logic [CELL_W-1:0]  host_rdata_o,
  input  logic [ROW_AW-1:0]  disp_row_i,
  input  logic [SCAN_AW-1:0] disp_scan_i,
  input  logic [COL_AW-1:0]  disp_col_i,
  input  logic               disp_load_i,
  input  logic               text_dot_i,
  input  logic               vblank_i,
  input  logic               ovl_en_i,
  output logic               pix_o
);
  localparam int NPORT = 2;  // 0: host, 1: display

  logic [HADDR_W-1:0] port_addr [NPORT];
  logic [LINE_W-1:0]  port_line [NPORT];
  logic [COL_AW-1:0]  port_col  [NPORT];
  logic               port_ok   [NPORT];
  cell_t              fetch_cell;

  assign port_addr[0] = host_addr_i;
  assign port_addr[1] = HADDR_W'({disp_scan_i, disp_row_i, disp_col_i});

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    gfx_ovl_addr_dec #(.COLS(COLS), .ROWS(ROWS), .SCANS(SCANS)) i_dec (
      .addr_i  (port_addr[p]),
      .line_o  (port_line[p]),
      .col_o   (port_col[p]),
      .valid_o (port_ok[p])
    );
  end

  gfx_ovl_store #(.COLS(COLS), .LINES(LINES)) i_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (host_we_i & port_ok[0]),
    .wr_line_i     (port_line[0]),
    .wr_col_i      (port_col[0]),
    .wr_data_i     (host_wdata_i),
    .rd_valid_i    (port_ok[0]),
    .rd_line_i     (port_line[0]),
    .rd_col_i      (port_col[0]),
    .rd_data_o     (host_rdata_o),
    .fetch_valid_i (disp_load_i & port_ok[1]),
    .fetch_line_i  (port_line[1]),
    .fetch_col_i   (port_col[1]),
    .fetch_data_o  (fetch_cell)
  );

  gfx_ovl_merge i_merge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (disp_load_i),
    .cell_i     (fetch_cell),
    .text_dot_i (text_dot_i),
    .vblank_i   (vblank_i),
    .ovl_en_i   (ovl_en_i),
    .pix_o      (pix_o)
  );

  // R4
  bad_scan_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(host_addr_i[SCAN_LSB +: SCAN_AW]) >= SCANS) |=> host_rdata_o == '0);
endmodule

// File: tb/test_gfx_overlay.sv
module test_gfx_overlay;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] host_addr_i = '0;
  logic        host_we_i = 1'b0;
  logic [5:0]  host_wdata_i = '0;
  logic [5:0]  host_rdata_o;
  logic [3:0]  disp_row_i = '0;
  logic [3:0]  disp_scan_i = '0;
  logic [5:0]  disp_col_i = '0;
  logic        disp_load_i = 1'b0;
  logic        text_dot_i = 1'b0;
  logic        vblank_i = 1'b0;
  logic        ovl_en_i = 1'b0;
  logic        pix_o;

  gfx_overlay i_gfx_overlay (
    .clk_i, .rst_ni, .host_addr_i, .host_we_i, .host_wdata_i, .host_rdata_o,
    .disp_row_i, .disp_scan_i, .disp_col_i, .disp_load_i, .text_dot_i,
    .vblank_i, .ovl_en_i, .pix_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    checks = 0, fails = 0;
  bit    done = 0, rd_ok = 0;
  string tag = "R1";

  // reference model
  int ovl [int];
  int m_rdata, m_pix, m_sh, m_en, m_vb;

  function automatic int key_of(int row, int scan, int col);
    return (row * 12 + scan) * 64 + col;
  endfunction

  function automatic int cell_at(int k);
    return ovl.exists(k) ? ovl[k] : 0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rdata = 0; m_pix = 0; m_sh = 0; m_en = 0; m_vb = 0;
    end else begin
      int hcol, hrow, hscan, hk, fetched;
      bit hvalid;
      hcol = host_addr_i[5:0]; hrow = host_addr_i[9:6]; hscan = host_addr_i[13:10];
      hvalid = hscan < 12;
      hk = key_of(hrow, hscan, hcol);
      fetched = (disp_scan_i < 12) ? cell_at(key_of(disp_row_i, disp_scan_i, disp_col_i)) : 0;
      m_rdata = hvalid ? cell_at(hk) : 0;
      m_pix = text_dot_i | (m_en & (m_sh & 1));
      m_sh = disp_load_i ? fetched : (m_sh >> 1);
      if (vblank_i && !m_vb) m_en = ovl_en_i;
      m_vb = vblank_i;
      if (host_we_i && hvalid) ovl[hk] = host_wdata_i;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    if (rd_ok) chk(tag, host_rdata_o, m_rdata);
    chk(tag, pix_o, m_pix);
  endtask

  function automatic logic [15:0] haddr(int row, int scan, int col);
    return 16'((scan << 10) | (row << 6) | col);
  endfunction

  task automatic hwrite(logic [15:0] a, int d);
    host_addr_i = a; host_we_i = 1'b1; host_wdata_i = 6'(d);
    step();
    host_we_i = 1'b0;
  endtask

  task automatic hread(logic [15:0] a);
    host_addr_i = a;
    step();
    step();
  endtask

  task automatic vblank_pulse(bit en);
    ovl_en_i = en; vblank_i = 1'b1;
    repeat (3) step();
    vblank_i = 1'b0;
    step();
  endtask

  // one display line; host keeps reading random written cells (R5)
  task automatic show_line(int row, int scan, int ncell, int dens);
    for (int c = 0; c < ncell; c++) begin
      for (int p = 0; p < 6; p++) begin
        disp_load_i = (p == 0);
        disp_row_i = 4'(row); disp_scan_i = 4'(scan); disp_col_i = 6'(c);
        text_dot_i = (($urandom % dens) == 0);
        host_addr_i = haddr(2, 5, $urandom % 64);
        step();
      end
    end
    disp_load_i = 1'b0;
    text_dot_i = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1", host_rdata_o, 0);
    chk("R1", pix_o, 0);
    rst_ni = 1'b1;
    step();

    // clear storage (read data undefined until done)
    tag = "R3";
    for (int s = 0; s < 12; s++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 64; c++) hwrite(haddr(r, s, c), 0);
    host_addr_i = '0;
    step();
    rd_ok = 1;
    step();

    // R3: writes, read-back, same-cycle read/write
    tag = "R3";
    for (int c = 0; c < 64; c++) hwrite(haddr(2, 5, c), $urandom % 64);
    for (int c = 0; c < 64; c++) hwrite(haddr(0, 0, c), (c % 2) ? 6'h15 : 6'h2a);
    for (int i = 0; i < 40; i++) hread(haddr($urandom % 16, $urandom % 12, $urandom % 64));
    hwrite(haddr(7, 11, 63), 6'h3f);
    hwrite(haddr(7, 11, 63), 6'h01);
    step();

    // R2: upper address bits are ignored
    tag = "R2";
    hwrite(16'hC000 | haddr(3, 4, 10), 6'h2d);
    hread(haddr(3, 4, 10));
    hwrite(haddr(15, 11, 0), 6'h33);
    hread(16'h4000 | haddr(15, 11, 0));
    hread(haddr(15, 11, 0));

    // R4: scan lines 12..15 are not stored
    tag = "R4";
    hwrite(haddr(1, 0, 0), 6'h11);
    hwrite(haddr(0, 12, 0), 6'h3f);
    hwrite(haddr(0, 15, 5), 6'h3f);
    hread(haddr(0, 12, 0));
    hread(haddr(1, 0, 0));
    hread(haddr(1, 3, 5));

    // R9: overlay latched off, text only
    tag = "R9";
    vblank_pulse(1'b0);
    show_line(2, 5, 16, 3);
    show_line(0, 0, 8, 2);

    // R8: latch on at vblank edge
    tag = "R8";
    vblank_pulse(1'b1);
    // R6, R7, R5: merged display with concurrent host reads
    tag = "R6";
    show_line(2, 5, 64, 1000);
    tag = "R7";
    show_line(2, 5, 64, 3);
    show_line(0, 0, 16, 2);
    tag = "R5";
    show_line(3, 4, 8, 4);

    // R10: no reload, overlay runs dry
    tag = "R10";
    repeat (12) step();

    // R11: invalid display scan line
    tag = "R11";
    show_line(0, 12, 6, 1000);
    show_line(2, 14, 6, 1000);

    // R8: ovl_en_i ignored outside vblank rise, hold vblank high
    tag = "R8";
    ovl_en_i = 1'b0;
    show_line(2, 5, 8, 1000);
    vblank_i = 1'b1;
    ovl_en_i = 1'b0;
    step();
    ovl_en_i = 1'b1;
    repeat (3) step();
    vblank_i = 1'b0;
    show_line(2, 5, 8, 1000);
    vblank_pulse(1'b1);
    show_line(0, 0, 8, 1000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule